// File: doc/BRIEF.md
# Per-Thread Debug Action Controller

This block turns debug compare events into actions for a core that runs four hardware threads. Each thread owns a 3-bit action code inside a 64-bit control word. When a thread's compare-event strobe is high, the block looks up that thread's code. Depending on the code, it then raises a stop request for that thread or for every thread, flags a fault for that thread, emits an external trigger pulse, or does nothing. Every event, whatever its code, also sets a sticky per-thread event status bit.

The control word is loaded through a plain write strobe and data bus. Stop requests, fault bits and event bits are sticky. Software clears them through write-one-to-clear strobe vectors. The block carries no streamed data, so every pin is a plain level or strobe with no valid/ready handshake. There is no back-pressure. Each input is sampled on every rising clock edge. All outputs are registered and change on the edge that samples the cause.

Top module: `dbg_action_ctl`

## Requirements
- R1: After reset, all stop, fault and event status outputs and the trigger output are 0, and every thread's action code is 000.
- R2: The code for thread t is taken from control bits [54+3t:52+3t] (bit 54+3t is the code MSB), so thread 0 uses 54:52 and thread 3 uses 63:61. Other control bits are ignored. A write takes effect for events sampled on later edges; an event in the write cycle uses the old code.
- R3: Codes 000 and 001 produce no stop, fault or trigger.
- R4: Code 010 on an event sets only that thread's stop request on the sampling edge.
- R5: Code 011 on an event sets the stop request of all four threads on the sampling edge.
- R6: Code 100 on an event sets that thread's bit in the 4-bit fault status.
- R7: Code 101 emits the trigger only. Code 110 emits the trigger and stops the thread that fired. Code 111 emits the trigger and stops all threads.
- R8: The trigger is high for exactly the one cycle after an edge that sampled at least one trigger-producing event. Requests from several threads in one cycle produce one pulse.
- R9: Any event on thread t sets event status bit t, whatever the code.
- R10: Stop, fault and event bits stay set until a 1 on the matching clear strobe bit clears them. A set in the same cycle as a clear wins.
- R11: When stop-all and stop-self requests arrive in the same cycle, the stop outputs are the OR of both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load control word |
| cfg_wdata | input | 64 | Control word holding the four action codes |
| evt_hit | input | 4 | Per-thread debug compare event strobe |
| stop_clr | input | 4 | Write-one-to-clear for stop requests |
| fault_clr | input | 4 | Write-one-to-clear for fault status |
| evt_clr | input | 4 | Write-one-to-clear for event status |
| stop_req | output | 4 | Sticky per-thread stop request |
| fault_sts | output | 4 | Sticky per-thread fault status |
| evt_sts | output | 4 | Sticky per-thread event status |
| ext_trig | output | 1 | One-cycle external trigger pulse |

## Verification
Random control words, event vectors and sparse clear strobes mix all eight codes across threads. Overlapping stop-all, stop-self and trigger requests therefore occur often, which separates an OR of requests from a priority pick. Directed cases place a single code in a single field to confirm field placement and show that the reserved code is inert. They also fire stop-all together with stop-self, and fire two trigger codes in one cycle so that one pulse is seen and not two. They collide a clear with a new set to show that the set wins. An event in the cycle that rewrites the control word shows whether the old code or the new one is applied.

// File: rtl/dbg_act_pkg.sv
package dbg_act_pkg;
  localparam int unsigned ACT_W = 3;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE       = 3'b000,
    ACT_RSVD       = 3'b001,
    ACT_HALT_SELF  = 3'b010,
    ACT_HALT_ALL   = 3'b011,
    ACT_FAULT      = 3'b100,
    ACT_TRIG       = 3'b101,
    ACT_TRIG_SELF  = 3'b110,
    ACT_TRIG_ALL   = 3'b111
  } act_code_e;
endpackage

// File: rtl/dbg_act_cfg.sv
module dbg_act_cfg
  import dbg_act_pkg::*;
#(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned REG_W = 64,
  parameter int unsigned BASE  = 52
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [REG_W-1:0]            wdata_i,
  output logic [NTHR-1:0][ACT_W-1:0]  code_o
);
  localparam int unsigned TOP_BIT = BASE + NTHR*ACT_W - 1;

  initial begin
    if (TOP_BIT >= REG_W) $error("action fields exceed control word");
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_fld
    localparam int unsigned LSB = BASE + t*ACT_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    code_o[t] <= ACT_NONE;
      else if (we_i) code_o[t] <= wdata_i[LSB +: ACT_W];
    end
  end
endmodule

// File: rtl/dbg_act_decode.sv
module dbg_act_decode
  import dbg_act_pkg::*;
#(
  parameter int unsigned NTHR = 4
) (
  input  logic [NTHR-1:0][ACT_W-1:0] code_i,
  input  logic [NTHR-1:0]            hit_i,
  output logic [NTHR-1:0]            halt_set_o,
  output logic                       halt_all_o,
  output logic [NTHR-1:0]            fault_set_o,
  output logic                       trig_o
);
  logic [NTHR-1:0] self_v;

  always_comb begin
    self_v      = '0;
    halt_all_o  = 1'b0;
    fault_set_o = '0;
    trig_o      = 1'b0;
    for (int t = 0; t < NTHR; t++) begin
      if (hit_i[t]) begin
        unique case (act_code_e'(code_i[t]))
          ACT_NONE, ACT_RSVD: ;
          ACT_HALT_SELF:  self_v[t] = 1'b1;
          ACT_HALT_ALL:   halt_all_o = 1'b1;
          ACT_FAULT:      fault_set_o[t] = 1'b1;
          ACT_TRIG:       trig_o = 1'b1;
          ACT_TRIG_SELF: begin
            trig_o    = 1'b1;
            self_v[t] = 1'b1;
          end
          ACT_TRIG_ALL: begin
            trig_o     = 1'b1;
            halt_all_o = 1'b1;
          end
          default: ;
        endcase
      end
    end
    halt_set_o = self_v | {NTHR{halt_all_o}};
  end
endmodule

// File: rtl/dbg_act_sticky.sv
module dbg_act_sticky #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i))); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R10
endmodule

// File: rtl/dbg_action_ctl.sv
module dbg_action_ctl
  import dbg_act_pkg::*;
#(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned REG_W = 64,
  parameter int unsigned BASE  = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [NTHR-1:0]  evt_hit,
  input  logic [NTHR-1:0]  stop_clr,
  input  logic [NTHR-1:0]  fault_clr,
  input  logic [NTHR-1:0]  evt_clr,
  output logic [NTHR-1:0]  stop_req,
  output logic [NTHR-1:0]  fault_sts,
  output logic [NTHR-1:0]  evt_sts,
  output logic             ext_trig
);
  logic [NTHR-1:0][ACT_W-1:0] codes;
  logic [NTHR-1:0]            halt_set;
  logic                       halt_all;
  logic [NTHR-1:0]            fault_set;
  logic                       trig_req;

  dbg_act_cfg #(.NTHR(NTHR), .REG_W(REG_W), .BASE(BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata), .code_o(codes)
  );

  dbg_act_decode #(.NTHR(NTHR)) u_dec (
    .code_i(codes), .hit_i(evt_hit), .halt_set_o(halt_set),
    .halt_all_o(halt_all), .fault_set_o(fault_set), .trig_o(trig_req)
  );

  dbg_act_sticky #(.W(NTHR)) u_stop (
    .clk(clk), .rst_n(rst_n), .set_i(halt_set), .clr_i(stop_clr), .q_o(stop_req)
  );
  dbg_act_sticky #(.W(NTHR)) u_fault (
    .clk(clk), .rst_n(rst_n), .set_i(fault_set), .clr_i(fault_clr), .q_o(fault_sts)
  );
  dbg_act_sticky #(.W(NTHR)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_hit), .clr_i(evt_clr), .q_o(evt_sts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_trig <= 1'b0;
    else        ext_trig <= trig_req;
  end

  AST_TRIG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig |-> $past(evt_hit != '0)); // R8
  AST_HALT_ALL_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    halt_all |=> (stop_req == '1)); // R5
  AST_STOP_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_req & ~$past(stop_req)) != '0) |-> $past(evt_hit != '0)); // R4
  AST_EVENT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit != '0) |=> ((evt_sts & $past(evt_hit)) == $past(evt_hit))); // R9
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_sts & ~$past(fault_sts)) != '0) |-> $past(evt_hit != '0)); // R6
endmodule

// File: tb/test_dbg_action_ctl.sv
module test_dbg_action_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [3:0]  evt_hit = '0, stop_clr = '0, fault_clr = '0, evt_clr = '0;
  logic [3:0]  stop_req, fault_sts, evt_sts;
  logic        ext_trig;

  int errors = 0;
  int checks = 0;

  logic [63:0] m_cfg = '0;
  logic [3:0]  m_stop = '0, m_fault = '0, m_evt = '0;
  logic        m_trig = 1'b0;

  always #5 clk = ~clk;

  dbg_action_ctl i_dbg_action_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .evt_hit(evt_hit), .stop_clr(stop_clr), .fault_clr(fault_clr), .evt_clr(evt_clr),
    .stop_req(stop_req), .fault_sts(fault_sts), .evt_sts(evt_sts), .ext_trig(ext_trig)
  );

  function automatic logic [2:0] code_of(logic [63:0] cfg, int t);
    return cfg[52 + 3*t +: 3];
  endfunction

  task automatic chk(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "stop_req R11", stop_req, m_stop);
    chk(tag, "fault_sts R6", fault_sts, m_fault);
    chk(tag, "evt_sts R9", evt_sts, m_evt);
    chk(tag, "ext_trig R8", {3'b0, ext_trig}, {3'b0, m_trig});
  endtask

  // apply inputs for one edge, update model, then compare at the next negedge
  task automatic step(logic we, logic [63:0] wd, logic [3:0] hit,
                      logic [3:0] sc, logic [3:0] fc, logic [3:0] ec, string tag);
    logic [3:0] sset, fset;
    logic       all, trg;
    logic [2:0] c;
    cfg_we = we; cfg_wdata = wd; evt_hit = hit;
    stop_clr = sc; fault_clr = fc; evt_clr = ec;
    sset = '0; fset = '0; all = 1'b0; trg = 1'b0;
    for (int t = 0; t < 4; t++) begin
      if (hit[t]) begin
        c = code_of(m_cfg, t);
        if (c == 3'b010 || c == 3'b110) sset[t] = 1'b1;
        if (c == 3'b011 || c == 3'b111) all = 1'b1;
        if (c == 3'b100) fset[t] = 1'b1;
        if (c >= 3'b101) trg = 1'b1;
      end
    end
    if (all) sset = 4'b1111;
    m_stop  = (m_stop & ~sc) | sset;
    m_fault = (m_fault & ~fc) | fset;
    m_evt   = (m_evt & ~ec) | hit;
    m_trig  = trg;
    if (we) m_cfg = wd;
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [63:0] fields(logic [2:0] c0, logic [2:0] c1,
                                         logic [2:0] c2, logic [2:0] c3);
    logic [63:0] w = '0;
    w[54:52] = c0; w[57:55] = c1; w[60:58] = c2; w[63:61] = c3;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    // R1: codes reset to 000, so events produce only event status
    step(0, '0, 4'b1111, 0, 0, 0, "R1 reset codes");
    step(0, '0, 0, 0, 0, 4'b1111, "R10 clear evt");

    // R2: only thread 2 field holds 100; other bits set to junk
    step(1, fields(0, 0, 3'b100, 0) | 64'h000F_FFFF_FFFF_FFFF, 4'b0100, 0, 0, 0, "R2 old code in write cycle");
    step(0, '0, 4'b0100, 0, 0, 0, "R2 field 60:58");
    chk("R2", "fault bit2 only", fault_sts, 4'b0100);
    step(0, '0, 0, 0, 4'b1111, 4'b1111, "R10 clear");

    // R3: reserved and none codes are inert
    step(1, fields(3'b001, 3'b000, 3'b001, 3'b000), 0, 0, 0, 0, "R3 cfg");
    step(0, '0, 4'b1111, 0, 0, 0, "R3 inert codes");
    chk("R3", "no stop", stop_req, 4'b0000);

    // R4 and R11: stop-self on thread 1, stop-all on thread 0, same cycle
    step(1, fields(3'b011, 3'b010, 3'b010, 3'b000), 0, 0, 0, 0, "R11 cfg");
    step(0, '0, 4'b0100, 0, 0, 0, "R4 self stop");
    chk("R4", "stop bit2 only", stop_req, 4'b0100);
    step(0, '0, 4'b0011, 4'b0100, 0, 0, "R11 all plus self");
    chk("R5", "all stopped", stop_req, 4'b1111);

    // R10: clear colliding with a new set keeps the bit
    step(0, '0, 4'b0010, 4'b1111, 0, 0, "R10 set wins");
    chk("R10", "bit1 kept", stop_req, 4'b0010);

    // R7 and R8: two trigger codes in one cycle, one pulse, then low
    step(1, fields(3'b101, 3'b000, 3'b000, 3'b110), 0, 4'b1111, 0, 4'b1111, "R7 cfg");
    step(0, '0, 4'b1001, 0, 0, 0, "R7 trig plus self stop");
    chk("R8", "single pulse", {3'b0, ext_trig}, 4'b0001);
    step(0, '0, 0, 0, 0, 0, "R8 pulse ends");
    chk("R8", "pulse low", {3'b0, ext_trig}, 4'b0000);
    step(1, fields(3'b111, 3'b000, 3'b000, 3'b000), 0, 4'b1111, 0, 0, "R7 cfg2");
    step(0, '0, 4'b0001, 0, 0, 0, "R7 trig all stop");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic        we;
      logic [63:0] wd;
      we = ($urandom % 8) == 0;
      wd = {$urandom, $urandom};
      step(we, wd, 4'($urandom),
           (($urandom % 4) == 0) ? 4'($urandom) : 4'b0,
           (($urandom % 4) == 0) ? 4'($urandom) : 4'b0,
           (($urandom % 4) == 0) ? 4'($urandom) : 4'b0,
           "R4/R5/R6/R7/R9/R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule